// File: doc/BRIEF.md
# Vector Operand Predicate Mask Lookup

This block produces the element-enable mask for one operand of a register-redirecting vector extension. An operand is named by a 5-bit architectural register number and a class select (integer or floating point). Each class has two configuration tables indexed by that number. The redirect table says whether the register is redirected at all. The predicate table says whether predication is on for it, and also holds an invert flag, a zeroing flag and a 6-bit index of the integer register that supplies the mask bits.

The lookup is combinational. The block drives the predicate table's target index onto a read address for the integer register file, and it takes the read data back. If both table entries for the operand are active, the mask is that register value, complemented when the invert flag is set. If either entry is inactive, the mask is all ones. The zeroing flag goes out with the mask.

For one element offset, the block also gives the single enable bit for that offset. It passes a remapped register selector through when the element is enabled and gives selector zero when it is not. The mask is XLEN bits wide, so the vector length cannot be more than XLEN. Both tables are filled through one synchronous write port.

Top module: `pred_mask_lookup`

## Requirements
- R1: After reset every entry of all four tables is inactive, so any lookup in either class gives an all-ones mask and a zeroing flag of 0.
- R2: When the operand's redirect entry is inactive, the mask is all ones and the zeroing flag is 0, even if its predicate entry is active.
- R3: When the redirect entry is active but the predicate entry is inactive, the mask is all ones and the zeroing flag is 0.
- R4: When both entries are active and the invert flag is clear, `rf_raddr` equals the predicate entry's target index and the mask equals `rf_rdata`.
- R5: When both entries are active and the invert flag is set, the mask is the bitwise complement of `rf_rdata`.
- R6: When both entries are active, the zeroing flag equals the predicate entry's zero bit.
- R7: The integer tables are used when `op_fp`=0 and the floating-point tables when `op_fp`=1. A write to one class never changes a lookup in the other class at the same index.
- R8: `elem_en` equals bit `elem_idx` of the mask. `sel_reg` equals `remap_reg` when `elem_en` is 1 and equals 0 otherwise.
- R9: A write takes place at the rising clock edge when `cfg_we`=1. `cfg_pred`=0 writes only the redirect entry's active bit, and `cfg_pred`=1 writes the whole predicate entry. The write goes to the class given by `cfg_fp` and the index given by `cfg_idx`. A lookup made in the cycle of the write shows the old contents. When `cfg_we`=0, no entry changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_pred | input | 1 | 0: redirect table, 1: predicate table |
| cfg_fp | input | 1 | 0: integer class, 1: floating-point class |
| cfg_idx | input | 5 | Entry index to write |
| cfg_active | input | 1 | Active bit to write |
| cfg_inv | input | 1 | Invert bit to write (predicate table) |
| cfg_zero | input | 1 | Zeroing bit to write (predicate table) |
| cfg_target | input | 6 | Mask source register index (predicate table) |
| op_idx | input | 5 | Operand architectural register number |
| op_fp | input | 1 | Operand class select |
| elem_idx | input | 6 | Element offset to test |
| remap_reg | input | 6 | Remapped register for this element |
| rf_raddr | output | 6 | Integer register file read address |
| rf_rdata | input | 64 | Integer register file read data |
| mask | output | 64 | Predicate mask |
| zeroing | output | 1 | Zeroing flag |
| elem_en | output | 1 | Enable of element `elem_idx` |
| sel_reg | output | 6 | Register selector, zero when the element is disabled |

## Verification
A table write and a lookup of the same entry can happen in the same cycle. The bench sets up this case by driving a redirect-enable write for an integer entry while `op_idx` already points at that entry. It samples the mask before the edge and expects the old all-ones value. It samples again after the edge and expects the fetched register value. It also applies a full write pattern with `cfg_we` low and then confirms that an earlier lookup result is unchanged.

// File: rtl/pml_pkg.sv
package pml_pkg;
    localparam int TGT_W = 6;

    typedef struct packed {
        logic             active;
        logic             inv;
        logic             zero;
        logic [TGT_W-1:0] target;
    } pred_ent_t;
endpackage

// File: rtl/pml_cfg_table.sv
module pml_cfg_table
    import pml_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_pred,
    input  logic [IDX_W-1:0] wr_idx,
    input  pred_ent_t        wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_redir,
    output pred_ent_t        rd_ent
);
    typedef struct packed {
        logic [NREG-1:0]      redir;
        pred_ent_t [NREG-1:0] pred;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            if (wr_pred) tbl_d.pred[wr_idx] = wr_ent;
            else         tbl_d.redir[wr_idx] = wr_ent.active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_redir = tbl_q.redir[rd_idx];
    assign rd_ent   = tbl_q.pred[rd_idx];

    assert_pred_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pred) |=> (tbl_q.pred[$past(wr_idx)] == $past(wr_ent)));
    assert_redir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_pred) |=> (tbl_q.redir[$past(wr_idx)] == $past(wr_ent.active)));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));
endmodule

// File: rtl/pml_mask_sel.sv
module pml_mask_sel
    import pml_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int EIDX_W = $clog2(XLEN)
) (
    input  logic              redir_on,
    input  pred_ent_t         ent,
    input  logic [XLEN-1:0]   rf_rdata,
    input  logic [EIDX_W-1:0] elem_idx,
    input  logic [TGT_W-1:0]  remap_reg,
    output logic [XLEN-1:0]   mask,
    output logic              zeroing,
    output logic              elem_en,
    output logic [TGT_W-1:0]  sel_reg
);
    logic live;

    always_comb begin
        live    = redir_on && ent.active;
        mask    = '1;
        zeroing = 1'b0;
        if (live) begin
            mask    = ent.inv ? ~rf_rdata : rf_rdata;
            zeroing = ent.zero;
        end
        elem_en = mask[elem_idx];
        sel_reg = elem_en ? remap_reg : '0;
    end
endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
    import pml_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDX_W  = $clog2(NREG),
    localparam int EIDX_W = $clog2(XLEN),
    localparam int NCLASS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_pred,
    input  logic              cfg_fp,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_active,
    input  logic              cfg_inv,
    input  logic              cfg_zero,
    input  logic [TGT_W-1:0]  cfg_target,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic              op_fp,
    input  logic [EIDX_W-1:0] elem_idx,
    input  logic [TGT_W-1:0]  remap_reg,
    output logic [TGT_W-1:0]  rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic [XLEN-1:0]   mask,
    output logic              zeroing,
    output logic              elem_en,
    output logic [TGT_W-1:0]  sel_reg
);
    pred_ent_t wr_ent;
    logic      cls_redir [NCLASS];
    pred_ent_t cls_ent   [NCLASS];
    logic      sel_redir;
    pred_ent_t sel_ent;

    assign wr_ent = '{active: cfg_active, inv: cfg_inv, zero: cfg_zero, target: cfg_target};

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        pml_cfg_table #(.NREG(NREG)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_fp == 1'(c))),
            .wr_pred (cfg_pred),
            .wr_idx  (cfg_idx),
            .wr_ent  (wr_ent),
            .rd_idx  (op_idx),
            .rd_redir(cls_redir[c]),
            .rd_ent  (cls_ent[c])
        );
    end

    assign sel_redir = cls_redir[op_fp];
    assign sel_ent   = cls_ent[op_fp];
    assign rf_raddr  = sel_ent.target;

    pml_mask_sel #(.XLEN(XLEN)) u_sel (
        .redir_on (sel_redir),
        .ent      (sel_ent),
        .rf_rdata (rf_rdata),
        .elem_idx (elem_idx),
        .remap_reg(remap_reg),
        .mask     (mask),
        .zeroing  (zeroing),
        .elem_en  (elem_en),
        .sel_reg  (sel_reg)
    );

    assert_redir_off_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_redir |-> (mask == '1 && !zeroing));
    assert_pred_off_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_redir && !sel_ent.active) |-> (mask == '1 && !zeroing));
    assert_fetch_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_redir && sel_ent.active && !sel_ent.inv) |-> (mask == rf_rdata));
    assert_fetch_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_redir && sel_ent.active && sel_ent.inv) |-> (mask == ~rf_rdata));
    assert_disabled_sel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_en |-> (sel_reg == '0));
endmodule

// File: tb/sim_pred_mask_lookup.sv
module sim_pred_mask_lookup;
    localparam int XLEN = 64;
    localparam time HALF = 2ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_pred = 1'b0, cfg_fp = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic        cfg_active = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0;
    logic [5:0]  cfg_target = '0;
    logic [4:0]  op_idx = '0;
    logic        op_fp = 1'b0;
    logic [5:0]  elem_idx = '0;
    logic [5:0]  remap_reg = '0;
    logic [5:0]  rf_raddr;
    logic [63:0] rf_rdata;
    logic [63:0] mask;
    logic        zeroing, elem_en;
    logic [5:0]  sel_reg;

    logic [63:0] rf [64];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign rf_rdata = rf[rf_raddr];

    always #HALF clk = ~clk;

    pred_mask_lookup u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pred(cfg_pred), .cfg_fp(cfg_fp),
        .cfg_idx(cfg_idx), .cfg_active(cfg_active), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
        .cfg_target(cfg_target), .op_idx(op_idx), .op_fp(op_fp), .elem_idx(elem_idx),
        .remap_reg(remap_reg), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mask(mask),
        .zeroing(zeroing), .elem_en(elem_en), .sel_reg(sel_reg)
    );

    function automatic logic [63:0] rfval(int i);
        return 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit pred, bit fp, int idx, bit act, bit inv, bit zero, int tgt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pred = pred; cfg_fp = fp; cfg_idx = 5'(idx);
        cfg_active = act; cfg_inv = inv; cfg_zero = zero; cfg_target = 6'(tgt);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(bit fp, int idx);
        @(negedge clk);
        op_fp = fp; op_idx = 5'(idx);
        #1;
    endtask

    task automatic t_reset;
        for (int r = 0; r < 32; r += 7) begin
            look(1'b0, r);
            check("R1 int mask", mask, '1);
            check("R1 int zero", 64'(zeroing), 0);
            look(1'b1, r);
            check("R1 fp mask", mask, '1);
        end
    endtask

    task automatic t_redir_off;
        wr(1'b1, 1'b0, 3, 1'b1, 1'b0, 1'b1, 10);
        look(1'b0, 3);
        check("R2 mask", mask, '1);
        check("R2 zero", 64'(zeroing), 0);
    endtask

    task automatic t_pred_off;
        wr(1'b0, 1'b0, 7, 1'b1, 1'b0, 1'b0, 0);
        look(1'b0, 7);
        check("R3 mask", mask, '1);
        check("R3 zero", 64'(zeroing), 0);
    endtask

    task automatic t_fetch;
        wr(1'b0, 1'b0, 3, 1'b1, 1'b0, 1'b0, 0);
        look(1'b0, 3);
        check("R4 raddr", 64'(rf_raddr), 10);
        check("R4 mask", mask, rfval(10));
        check("R6 zero set", 64'(zeroing), 1);
    endtask

    task automatic t_invert;
        wr(1'b1, 1'b0, 7, 1'b1, 1'b1, 1'b0, 33);
        look(1'b0, 7);
        check("R5 mask", mask, ~rfval(33));
        check("R6 zero clear", 64'(zeroing), 0);
    endtask

    task automatic t_class;
        look(1'b1, 3);
        check("R7 fp untouched", mask, '1);
        wr(1'b0, 1'b1, 3, 1'b1, 1'b0, 1'b0, 0);
        wr(1'b1, 1'b1, 3, 1'b1, 1'b0, 1'b0, 20);
        look(1'b1, 3);
        check("R7 fp mask", mask, rfval(20));
        check("R7 fp zero", 64'(zeroing), 0);
        look(1'b0, 3);
        check("R7 int kept", mask, rfval(10));
    endtask

    task automatic t_elem;
        logic [63:0] m;
        m = rfval(10);
        look(1'b0, 3);
        remap_reg = 6'd45;
        for (int e = 0; e < XLEN; e++) begin
            @(negedge clk);
            elem_idx = 6'(e);
            #1;
            check("R8 elem_en", 64'(elem_en), 64'(m[e]));
            check("R8 sel_reg", 64'(sel_reg), m[e] ? 64'd45 : 64'd0);
        end
        look(1'b0, 9);
        check("R8 all-on sel", 64'(sel_reg), 45);
    endtask

    task automatic t_same_cycle;
        wr(1'b1, 1'b0, 12, 1'b1, 1'b0, 1'b0, 5);
        @(negedge clk);
        op_fp = 1'b0; op_idx = 5'd12;
        cfg_we = 1'b1; cfg_pred = 1'b0; cfg_fp = 1'b0; cfg_idx = 5'd12; cfg_active = 1'b1;
        #1;
        check("R9 old during write", mask, '1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R9 new after edge", mask, rfval(5));
        @(negedge clk);
        cfg_we = 1'b0; cfg_pred = 1'b1; cfg_fp = 1'b0; cfg_idx = 5'd3;
        cfg_active = 1'b0; cfg_inv = 1'b1; cfg_target = 6'd0;
        @(negedge clk);
        look(1'b0, 3);
        check("R9 no write when idle", mask, rfval(10));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) rf[i] = rfval(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_redir_off();
        t_pred_off();
        t_fetch();
        t_invert();
        t_class();
        t_elem();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule